// File: doc/BRIEF.md
# Dual-Width Add Flag Unit

This block performs one 64-bit addition per accepted request and derives two condition-code sets from that single sum. One set describes the result seen as a 32-bit word, the other the full 64-bit result. The sum and both flag sets are held in registers that load on a clock edge where the valid strobe is high. This lets an execution pipeline keep the narrow and wide flag views without a second adder.

Four operations are supported: plain add with flags, add with carry with flags, add with carry that leaves the flags alone, and tagged add with flags. The add-with-carry operations feed in the stored 32-bit carry flag, which the surrounding pipeline supplies on a dedicated input. Tagged add marks the 32-bit overflow flag whenever either operand has a nonzero value in its two low tag bits. The 64-bit overflow flag is left with its ordinary arithmetic value.

The 32-bit carry is not taken from a separate narrow adder. It is recovered as the carry into bit 32 of the wide add, which is bit 32 of the sum XOR both operands. There is no sequencing, so the block has no state machine: each accepted request updates the registers in one cycle.

Top module: `dual_width_addflag`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high on a rising edge, `sum_q`, `nzvc_lo` and `nzvc_hi` become zero.
- R2: On a rising edge with `in_valid` high, `sum_q` loads (`opa` + `opb` + cin) mod 2^64. The opcode `op` is encoded as 2'b00 add with flags, 2'b01 add with carry and flags, 2'b10 add with carry without flags, and 2'b11 tagged add with flags. cin is 0 for 2'b00 and 2'b11, and equals `carry32_in` for 2'b01 and 2'b10.
- R3: The 64-bit carry flag (`nzvc_hi` bit 0) is the carry out of bit 63 of the addition.
- R4: The 32-bit carry flag (`nzvc_lo` bit 0) is the carry into bit 32, equal to the carry out of the low-32-bit addition including cin.
- R5: The overflow flags (bit 1 of each set) are set when both addends have the same sign bit and the result's sign bit differs from it. The sign bit is bit 31 for `nzvc_lo` and bit 63 for `nzvc_hi`.
- R6: The negative flag (bit 3) is the result's sign bit, and the zero flag (bit 2) is set when the result is zero. For `nzvc_lo` both are taken over bits 31:0 of the sum; for `nzvc_hi` they are taken over all 64 bits.
- R7: For tagged add (2'b11), the 32-bit overflow flag is also set when bits 1:0 of (`opa` OR `opb`) are nonzero. The 64-bit overflow flag keeps the value R5 gives it.
- R8: Add with carry without flags (2'b10) updates `sum_q` per R2 but leaves `nzvc_lo` and `nzvc_hi` unchanged.
- R9: On a rising edge with `in_valid` low and no reset, `sum_q`, `nzvc_lo` and `nzvc_hi` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; registers load when high |
| op | input | 2 | Operation select (encoding in R2) |
| opa | input | 64 | First addend |
| opb | input | 64 | Second addend |
| carry32_in | input | 1 | Stored 32-bit carry flag used by the carry operations |
| sum_q | output | 64 | Registered sum |
| nzvc_lo | output | 4 | Registered 32-bit flags: bit 3 N, bit 2 Z, bit 1 V, bit 0 C |
| nzvc_hi | output | 4 | Registered 64-bit flags: bit 3 N, bit 2 Z, bit 1 V, bit 0 C |

## Verification
The bound checker watches several properties on every cycle: the clearing on reset, the registered sum against the past operands and carry-in, the flag hold for the no-flags opcode and for idle cycles, and the negative and zero flags against the registered sum. It also checks that a tagged add with nonzero tag bits always raises the narrow overflow flag. The carry and overflow flags depend on values a property cannot see in the registered outputs. Those flags are shown by the bench's 65-bit and 33-bit reference arithmetic over corner operands (all ones, sign-boundary values, nonzero tag bits) and several hundred random requests.

// File: rtl/dwaf_pkg.sv
package dwaf_pkg;

    typedef enum logic [1:0] {
        OP_ADD      = 2'b00,
        OP_ADDC     = 2'b01,
        OP_ADDC_NF  = 2'b10,
        OP_TADD     = 2'b11
    } dwaf_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic cry;
    } dwaf_flags_t;

    localparam int unsigned TAG_BITS = 2;

endpackage

// File: rtl/dwaf_adder.sv
module dwaf_adder #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
    end
endmodule

// File: rtl/dwaf_flag_slice.sv
module dwaf_flag_slice
    import dwaf_pkg::*;
#(
    parameter int unsigned SW = 32
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    input  logic [SW-1:0] sum,
    input  logic          carry,
    input  logic          force_ovf,
    output dwaf_flags_t   flags
);
    logic [SW-1:0] ovf_vec;

    always_comb begin
        ovf_vec     = (sum ^ b) & ~(a ^ b);
        flags.neg   = sum[SW-1];
        flags.zero  = ~|sum;
        flags.ovf   = ovf_vec[SW-1] | force_ovf;
        flags.cry   = carry;
    end
endmodule

// File: rtl/dual_width_addflag.sv
module dual_width_addflag
    import dwaf_pkg::*;
#(
    parameter int unsigned W    = 64,
    parameter int unsigned LO_W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         carry32_in,
    output logic [W-1:0] sum_q,
    output logic [3:0]   nzvc_lo,
    output logic [3:0]   nzvc_hi
);
    localparam int unsigned NSLICE = 2;

    dwaf_op_e     op_e;
    logic         cin;
    logic [W-1:0] sum;
    logic         cout_hi;
    logic [W-1:0] carry_trace;
    logic         tag_hit;
    logic         update_flags;
    dwaf_flags_t  slice_flags [NSLICE];
    dwaf_flags_t  lo_q;
    dwaf_flags_t  hi_q;

    always_comb begin
        op_e         = dwaf_op_e'(op);
        cin          = (op_e == OP_ADDC || op_e == OP_ADDC_NF) ? carry32_in : 1'b0;
        tag_hit      = (op_e == OP_TADD) && (|(opa[TAG_BITS-1:0] | opb[TAG_BITS-1:0]));
        update_flags = (op_e != OP_ADDC_NF);
        carry_trace  = sum ^ opa ^ opb;
    end

    dwaf_adder #(.W(W)) u_add (
        .a    (opa),
        .b    (opb),
        .cin  (cin),
        .sum  (sum),
        .cout (cout_hi)
    );

    for (genvar gi = 0; gi < NSLICE; gi++) begin : g_slice
        localparam int unsigned SW = (gi == 0) ? LO_W : W;
        dwaf_flag_slice #(.SW(SW)) u_slice (
            .a         (opa[SW-1:0]),
            .b         (opb[SW-1:0]),
            .sum       (sum[SW-1:0]),
            .carry     ((gi == 0) ? carry_trace[LO_W] : cout_hi),
            .force_ovf ((gi == 0) ? tag_hit : 1'b0),
            .flags     (slice_flags[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (in_valid) begin
            sum_q <= sum;
            if (update_flags) begin
                lo_q <= slice_flags[0];
                hi_q <= slice_flags[1];
            end
        end
    end

    assign nzvc_lo = lo_q;
    assign nzvc_hi = hi_q;
endmodule

// File: rtl/dwaf_checker.sv
module dwaf_checker #(
    parameter int unsigned W    = 64,
    parameter int unsigned LO_W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   op,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         carry32_in,
    input logic [W-1:0] sum_q,
    input logic [3:0]   nzvc_lo,
    input logic [3:0]   nzvc_hi
);
    logic         chk_cin;
    logic [W-1:0] chk_addend;
    logic         chk_tag;

    assign chk_cin    = carry32_in & (op == 2'b01 || op == 2'b10);
    assign chk_addend = opb + {{(W-1){1'b0}}, chk_cin};
    assign chk_tag    = (op == 2'b11) && ((opa[1:0] | opb[1:0]) != 2'b00);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (sum_q == '0 && nzvc_lo == 4'b0 && nzvc_hi == 4'b0));

    assert_sum_value_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> sum_q == $past(opa) + $past(chk_addend));

    assert_nz_track_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op != 2'b10) |=>
            (nzvc_hi[3] == sum_q[W-1] && nzvc_hi[2] == (sum_q == '0) &&
             nzvc_lo[3] == sum_q[LO_W-1] && nzvc_lo[2] == (sum_q[LO_W-1:0] == '0)));

    assert_tag_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && chk_tag) |=> nzvc_lo[1]);

    assert_noflag_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b10) |=> ($stable(nzvc_lo) && $stable(nzvc_hi)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(sum_q) && $stable(nzvc_lo) && $stable(nzvc_hi)));
endmodule

bind dual_width_addflag dwaf_checker #(.W(W), .LO_W(LO_W)) u_dwaf_checker (.*);

// File: tb/tb_dual_width_addflag.sv
module tb_dual_width_addflag;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [63:0] opa, opb;
    logic        carry32_in;
    logic [63:0] sum_q;
    logic [3:0]  nzvc_lo, nzvc_hi;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [63:0] m_sum;
    logic [3:0]  m_lo, m_hi;

    always #5 clk = ~clk;

    dual_width_addflag dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .carry32_in(carry32_in),
        .sum_q(sum_q), .nzvc_lo(nzvc_lo), .nzvc_hi(nzvc_hi)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic compare_all(input logic [1:0] o, input bit was_valid);
        string sreq;
        sreq = !was_valid ? "R9 sum" : "R2 sum";
        chk(sreq, sum_q, m_sum);
        if (!was_valid || o == 2'b10) begin
            chk(was_valid ? "R8 lo flags" : "R9 lo flags", {60'b0, nzvc_lo}, {60'b0, m_lo});
            chk(was_valid ? "R8 hi flags" : "R9 hi flags", {60'b0, nzvc_hi}, {60'b0, m_hi});
        end else begin
            chk("R3 C64", {63'b0, nzvc_hi[0]}, {63'b0, m_hi[0]});
            chk("R4 C32", {63'b0, nzvc_lo[0]}, {63'b0, m_lo[0]});
            chk("R5 V64", {63'b0, nzvc_hi[1]}, {63'b0, m_hi[1]});
            chk(o == 2'b11 ? "R7 V32" : "R5 V32", {63'b0, nzvc_lo[1]}, {63'b0, m_lo[1]});
            chk("R6 NZ64", {62'b0, nzvc_hi[3:2]}, {62'b0, m_hi[3:2]});
            chk("R6 NZ32", {62'b0, nzvc_lo[3:2]}, {62'b0, m_lo[3:2]});
        end
    endtask

    task automatic step(input bit v, input logic [1:0] o, input logic [63:0] a,
                        input logic [63:0] b, input logic c);
        logic [64:0] wide;
        logic [32:0] narrow;
        logic        ci;
        logic [63:0] s;
        in_valid = v; op = o; opa = a; opb = b; carry32_in = c;
        if (v) begin
            ci     = (o == 2'b01 || o == 2'b10) ? c : 1'b0;
            wide   = 65'(a) + 65'(b) + 65'(ci);
            narrow = 33'(a[31:0]) + 33'(b[31:0]) + 33'(ci);
            s      = wide[63:0];
            m_sum  = s;
            if (o != 2'b10) begin
                m_hi[3] = s[63];
                m_hi[2] = (s == 64'd0);
                m_hi[1] = (a[63] == b[63]) && (s[63] != a[63]);
                m_hi[0] = wide[64];
                m_lo[3] = s[31];
                m_lo[2] = (s[31:0] == 32'd0);
                m_lo[1] = ((a[31] == b[31]) && (s[31] != a[31])) ||
                          (o == 2'b11 && (a[1:0] | b[1:0]) != 2'b00);
                m_lo[0] = narrow[32];
            end
        end
        @(posedge clk);
        #1;
        compare_all(o, v);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        m_sum = '0; m_lo = '0; m_hi = '0;
        chk("R1 sum", sum_q, 64'd0);
        chk("R1 lo", {60'b0, nzvc_lo}, 64'd0);
        chk("R1 hi", {60'b0, nzvc_hi}, 64'd0);
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = 2'b00; opa = '0; opb = '0; carry32_in = 1'b0;
        do_reset();
        // R3/R4 carries out of all-ones
        step(1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
        step(1, 2'b00, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0);
        // R5 sign-boundary overflows
        step(1, 2'b00, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
        step(1, 2'b00, 64'h0000_0000_7FFF_FFFF, 64'd1, 1'b0);
        step(1, 2'b00, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 1'b0);
        // R2 carry-in included for carry ops, ignored for plain add
        step(1, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1);
        step(1, 2'b00, 64'd5, 64'd6, 1'b1);
        step(1, 2'b01, 64'h0000_0000_7FFF_FFFF, 64'd0, 1'b1);
        // R8 no-flag carry add after flags were set
        step(1, 2'b10, 64'd10, 64'd20, 1'b1);
        step(1, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1);
        // R7 tag bits: V32 forced, V64 arithmetic
        step(1, 2'b11, 64'd1, 64'd4, 1'b1);
        step(1, 2'b11, 64'd4, 64'd2, 1'b0);
        step(1, 2'b11, 64'd4, 64'd8, 1'b0);
        step(1, 2'b11, 64'h7FFF_FFFF_FFFF_FFFC, 64'h4, 1'b0);
        // R9 idle cycles hold
        step(0, 2'b00, 64'd1, 64'd1, 1'b1);
        step(0, 2'b11, 64'd3, 64'd3, 1'b0);
        for (int i = 0; i < 400; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (i % 7 == 0) ra[31:0] = 32'hFFFF_FFFF;
            if (i % 11 == 0) rb = ~ra;
            step(($urandom % 5) != 0, 2'($urandom), ra, rb, 1'($urandom));
        end
        // R1 reset from a nonzero state
        step(1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        do_reset();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule